// File: doc/BRIEF.md
# I2C Register Target with Word-Granular Auto-Increment

This block is an I2C target that opens a 16-bit subaddress space onto an internal byte store. It oversamples SCL and SDA with the system clock, spots start, repeated start and stop conditions, matches a 7-bit device address and moves bytes in both directions. The block drives SDA as an open-drain line: one output asks the pad to pull the line low, and releasing that output lets the line float high.

A write frame carries the device address with R/W cleared, two subaddress bytes and then any number of data bytes. A read frame first sets the subaddress through a short write, then uses a repeated start and the device address with R/W set. If the repeated start and address come with no subaddress phase, the read starts at the current pointer. The pointer does not step on every byte. The subaddress is decoded into a word length of one to five bytes, and the pointer steps once for each complete word. A word that a stop or start cuts short is dropped, and the pointer stays on that word.

Top module: `i2c_regslave`

## Requirements
- R1: After reset the SDA pull-down is released, the subaddress pointer is 0x0000 and every storage byte reads as 0x00.
- R2: The first byte after a start holds the 7-bit device address (default 0x34) in bits 7..1 and R/W in bit 0. On a mismatch the target gives no acknowledge and ignores all following bytes until the next start.
- R3: After an address match the target pulls SDA low during the ninth SCL clock of every byte it receives.
- R4: In a write frame the two bytes after the address are the subaddress, high byte first, then low byte. Every later byte is data for the word at the pointer.
- R5: Word length is decoded from the pointer: 0x0000–0x03FF gives 4 bytes, 0x0800–0x0FFF gives 5 bytes, 0x1000–0x1FFF gives 2 bytes, and every other subaddress gives 1 byte.
- R6: During a burst the pointer advances by one, wrapping from 0xFFFF to 0x0000, only after a complete word has been transferred. Written data reaches storage when its word is complete.
- R7: After a matched address with R/W=1 the target drives bytes MSB first, starting at byte 0 of the word at the pointer. The pointer is either the subaddress just written or the one left by earlier frames.
- R8: Each byte sent to the master counts toward the word, whether it is acknowledged or not. A master acknowledge continues the output. A not-acknowledge makes the target release SDA and stay silent until the next start.
- R9: A start or stop in the middle of a word discards that word's bytes. Storage is left unchanged, and the pointer stays on the word.
- R10: Byte k of the word at subaddress A is held in storage location A[4:0]*8 + k, so subaddresses that agree in bits 4..0 share storage.
- R11: The target changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low; low releases it |

## Verification
The hardest case to reach is a word cut short. A stop or repeated start must land after some bytes of a multi-byte word but before its last byte, in a region whose length is not the one just left. The only way to see the result at the ports is a later read that starts at the held pointer. The stimulus uses bursts whose length is not a multiple of the word length, repeated starts placed right after a data byte, and reads with no subaddress phase. Bursts starting on every region boundary, including the 0xFFFF wrap, make the decoded length change in the middle of a frame.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int SUB_W    = 16;
  localparam int SLOT_LG  = 3;
  localparam int MAX_WORD = 5;
  localparam int WORDS_LG = 5;
  localparam int STORE_LG = WORDS_LG + SLOT_LG;
  localparam int STORE_N  = 1 << STORE_LG;
  localparam int BUF_N    = MAX_WORD - 1;
  localparam int BUF_LG   = $clog2(BUF_N);

  localparam logic [SUB_W-1:0] QUAD_END  = 16'h0400;
  localparam logic [SUB_W-1:0] PENTA_LO  = 16'h0800;
  localparam logic [SUB_W-1:0] PENTA_END = 16'h1000;
  localparam logic [SUB_W-1:0] PAIR_END  = 16'h2000;

  typedef logic [SUB_W-1:0]    sub_t;
  typedef logic [SLOT_LG-1:0]  slot_t;
  typedef logic [STORE_LG-1:0] sidx_t;

  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_ACK, L_RX, L_TX, L_MACK, L_WAIT
  } link_st_t;

  // bytes per word for the region the subaddress falls in
  function automatic slot_t word_len(sub_t a);
    if (a < QUAD_END)                      return slot_t'(4);
    else if (a >= PENTA_LO && a < PENTA_END) return slot_t'(5);
    else if (a >= PENTA_END && a < PAIR_END) return slot_t'(2);
    else                                   return slot_t'(1);
  endfunction

  // storage location of byte k of the word at subaddress a
  function automatic sidx_t store_index(sub_t a, slot_t k);
    return {a[WORDS_LG-1:0], k};
  endfunction
endpackage

// File: rtl/i2c_rs_lineio.sv
module i2c_rs_lineio #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rs_link.sv
module i2c_rs_link import i2c_rs_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h34
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic [7:0] rx_byte,
  output logic       sub_hi_v,
  output logic       sub_lo_v,
  output logic       data_v,
  output logic       tx_done,
  output logic       nack_ev,
  output logic       addr_miss
);
  link_st_t   st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw_q, m_ack;
  logic [1:0] wr_cnt;
  logic       byte_end, rx_end;

  assign byte_end  = scl_fall && (cnt == 4'd8);
  assign rx_end    = (st == L_RX) && byte_end;
  assign addr_miss = (st == L_ADDR) && byte_end && (sh[7:1] != DEV_ADDR);
  assign sub_hi_v  = rx_end && (wr_cnt == 2'd0);
  assign sub_lo_v  = rx_end && (wr_cnt == 2'd1);
  assign data_v    = rx_end && (wr_cnt == 2'd2);
  assign rx_byte   = sh;
  assign tx_done   = (st == L_MACK) && scl_rise;
  assign nack_ev   = tx_done && sda_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= L_IDLE;
      cnt    <= '0;
      sh     <= '0;
      rw_q   <= 1'b0;
      m_ack  <= 1'b0;
      wr_cnt <= '0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      st     <= L_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st     <= L_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        L_ADDR, L_RX: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            if (st == L_RX) begin
              sda_oe <= 1'b1;
              st     <= L_ACK;
              if (wr_cnt != 2'd2) wr_cnt <= wr_cnt + 2'd1;
            end else if (sh[7:1] == DEV_ADDR) begin
              rw_q   <= sh[0];
              wr_cnt <= '0;
              sda_oe <= 1'b1;
              st     <= L_ACK;
            end else begin
              st <= L_WAIT;
            end
          end
        end
        L_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw_q) begin
              st     <= L_TX;
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              st     <= L_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        L_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              st     <= L_MACK;
              sda_oe <= 1'b0;
              m_ack  <= 1'b0;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        end
        L_MACK: begin
          if (scl_rise) begin
            if (sda_s) st <= L_WAIT;
            else       m_ack <= 1'b1;
          end else if (scl_fall && m_ack) begin
            st     <= L_TX;
            cnt    <= '0;
            sh     <= rd_byte;
            sda_oe <= ~rd_byte[7];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rs_store.sv
module i2c_rs_store import i2c_rs_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       sub_hi_v,
  input  logic       sub_lo_v,
  input  logic       data_v,
  input  logic       tx_done,
  input  logic [7:0] byte_in,
  output logic [7:0] rd_byte,
  output sub_t       ptr,
  output slot_t      bidx,
  output slot_t      wlen,
  output logic       word_done
);
  logic [7:0] mem  [STORE_N];
  logic [7:0] wbuf [BUF_N];
  logic [7:0] hi_q;
  logic       last;

  assign wlen      = word_len(ptr);
  assign last      = (bidx == wlen - slot_t'(1));
  assign word_done = (data_v || tx_done) && last;
  assign rd_byte   = mem[store_index(ptr, bidx)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      bidx <= '0;
      hi_q <= '0;
      for (int k = 0; k < BUF_N; k++) wbuf[k] <= '0;
    end else if (abort) begin
      bidx <= '0;
    end else if (sub_hi_v) begin
      hi_q <= byte_in;
    end else if (sub_lo_v) begin
      ptr  <= {hi_q, byte_in};
      bidx <= '0;
    end else if (data_v || tx_done) begin
      if (last) begin
        ptr  <= ptr + sub_t'(1);
        bidx <= '0;
      end else begin
        if (data_v) wbuf[bidx[BUF_LG-1:0]] <= byte_in;
        bidx <= bidx + slot_t'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < STORE_N; j++) mem[j] <= '0;
    end else if (data_v && last) begin
      for (int k = 0; k < BUF_N; k++)
        if (slot_t'(k) < bidx) mem[store_index(ptr, slot_t'(k))] <= wbuf[k];
      mem[store_index(ptr, bidx)] <= byte_in;
    end
  end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave import i2c_rs_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       abort_ev, sub_hi_v, sub_lo_v, data_v, tx_done, nack_ev, addr_miss;
  logic       word_done;
  logic [7:0] rx_byte, rd_byte;
  sub_t       ptr;
  slot_t      bidx, wlen;

  assign abort_ev = start_ev | stop_ev;

  i2c_rs_lineio #(.STAGES(STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_rs_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .rx_byte(rx_byte),
    .sub_hi_v(sub_hi_v), .sub_lo_v(sub_lo_v), .data_v(data_v),
    .tx_done(tx_done), .nack_ev(nack_ev), .addr_miss(addr_miss)
  );

  i2c_rs_store u_store (
    .clk(clk), .rst_n(rst_n), .abort(abort_ev), .sub_hi_v(sub_hi_v),
    .sub_lo_v(sub_lo_v), .data_v(data_v), .tx_done(tx_done),
    .byte_in(rx_byte), .rd_byte(rd_byte), .ptr(ptr), .bidx(bidx),
    .wlen(wlen), .word_done(word_done)
  );
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk import i2c_rs_pkg::*; (
  input logic  clk,
  input logic  rst_n,
  input logic  scl_i,
  input logic  sda_oe,
  input logic  word_done,
  input logic  abort_ev,
  input logic  nack_ev,
  input logic  addr_miss,
  input sub_t  ptr,
  input slot_t bidx,
  input slot_t wlen
);
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  p_slot_in_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bidx < wlen);

  p_word_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (ptr == $past(ptr) + sub_t'(1)) && (bidx == '0));

  p_abort_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (bidx == '0) && $stable(ptr));

  p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> !sda_oe);

  p_miss_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe);
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .word_done(word_done), .abort_ev(abort_ev), .nack_ev(nack_ev),
  .addr_miss(addr_miss), .ptr(ptr), .bidx(bidx), .wlen(wlen)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
  localparam logic [6:0] DEV = 7'h34;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  wire  sda = ~(m_low | sda_oe);

  int checks = 0;
  int errors = 0;
  int r11_bad = 0;
  bit finished = 1'b0;

  logic [7:0]  mdl [256];
  logic [15:0] mptr = 16'h0000;

  always #5 clk = ~clk;

  i2c_regslave #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe)
  );

  // R11 monitor: the pull-down may only move while SCL is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl) r11_bad++;
    oe_prev <= sda_oe;
  end

  function automatic int mlen(input logic [15:0] a);
    if (a < 16'h0400) return 4;
    if (a >= 16'h0800 && a < 16'h1000) return 5;
    if (a >= 16'h1000 && a < 16'h2000) return 2;
    return 1;
  endfunction

  function automatic int midx(input logic [15:0] a, input int k);
    return int'(a[4:0]) * 8 + k;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq(); wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    m_low = 1'b0; wq(); scl = 1'b1; wq(); acked = !sda; wq(); scl = 1'b0; wq();
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1'b1; wq(); b = {b[6:0], sda}; wq(); scl = 1'b0; wq();
    end
    m_low = ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); m_low = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input bit leave_open, input string tag);
    logic [7:0] wb [5];
    int bi;
    bit ak;
    logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, ak); check(ak, "R2", 16'(ak), 16'd1);
    put_byte(a[15:8], ak);     check(ak, "R3", 16'(ak), 16'd1);
    put_byte(a[7:0], ak);      check(ak, "R4", 16'(ak), 16'd1);
    mptr = a; bi = 0;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      put_byte(d, ak); check(ak, "R3", 16'(ak), 16'd1);
      wb[bi] = d; bi++;
      if (bi == mlen(mptr)) begin
        for (int k = 0; k < bi; k++) mdl[midx(mptr, k)] = wb[k];
        mptr = mptr + 16'd1; bi = 0;
      end
    end
    if (!leave_open) bus_stop();
  endtask

  task automatic do_read(input bit set_sub, input logic [15:0] a, input int n, input bit tail, input string tag);
    bit ak;
    int bi;
    logic [7:0] got;
    bus_start();
    if (set_sub) begin
      put_byte({DEV, 1'b0}, ak); check(ak, "R2", 16'(ak), 16'd1);
      put_byte(a[15:8], ak);     check(ak, "R4", 16'(ak), 16'd1);
      put_byte(a[7:0], ak);      check(ak, "R4", 16'(ak), 16'd1);
      mptr = a;
      bus_start();
    end
    put_byte({DEV, 1'b1}, ak); check(ak, "R7", 16'(ak), 16'd1);
    bi = 0;
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, got);
      check(got === mdl[midx(mptr, bi)], tag, 16'(got), 16'(mdl[midx(mptr, bi)]));
      bi++;
      if (bi == mlen(mptr)) begin mptr = mptr + 16'd1; bi = 0; end
    end
    if (tail) begin
      for (int i = 0; i < 9; i++) begin
        wq(); scl = 1'b1; wq(); check(sda === 1'b1, "R8", 16'(sda), 16'd1); wq(); scl = 1'b0; wq();
      end
    end
    bus_stop();
  endtask

  task automatic bad_frame();
    bit ak;
    bus_start();
    put_byte({DEV ^ 7'h01, 1'b0}, ak); check(!ak, "R2", 16'(ak), 16'd0);
    for (int i = 0; i < 4; i++) begin
      put_byte(8'($urandom), ak); check(!ak, "R2", 16'(ak), 16'd0);
    end
    bus_stop();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      summary();
    end
  end

  initial begin
    logic [15:0] pool [9];
    pool = '{16'h03FF, 16'h0400, 16'h07FF, 16'h0800, 16'h0FFF,
             16'h1000, 16'h1FFF, 16'h2000, 16'hFFFF};
    void'($urandom(32'h5eed1234));
    for (int j = 0; j < 256; j++) mdl[j] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: released line, pointer at zero, storage cleared
    check(sda_oe === 1'b0, "R1", 16'(sda_oe), 16'd0);
    do_read(1'b0, 16'h0000, 4, 1'b0, "R1");

    // R4 R6: burst across two 4-byte words, then read back
    do_write(16'h0010, 8, 1'b0, "R4");
    do_read(1'b1, 16'h0010, 8, 1'b0, "R6");

    // R8: NACK ends output, line stays released
    do_read(1'b1, 16'h0010, 3, 1'b1, "R8");

    // R2: wrong device address leaves storage and pointer alone
    do_write(16'h0014, 0, 1'b0, "R4");
    bad_frame();
    do_read(1'b0, 16'h0000, 4, 1'b0, "R2");

    // R9: partial write word dropped on stop, pointer kept
    do_write(16'h0010, 2, 1'b0, "R9");
    do_read(1'b0, 16'h0000, 4, 1'b0, "R9");
    // R9: partial 5-byte word dropped on repeated start
    do_write(16'h0808, 7, 1'b1, "R9");
    do_read(1'b0, 16'h0000, 3, 1'b0, "R9");
    // R9: partial read word leaves pointer on that word
    do_read(1'b1, 16'h0010, 2, 1'b0, "R9");
    do_read(1'b0, 16'h0000, 4, 1'b0, "R9");

    // R10: aliasing of subaddresses that share bits 4..0
    do_write(16'h0025, 4, 1'b0, "R10");
    do_read(1'b1, 16'h0005, 4, 1'b0, "R10");

    // R5: bursts starting on every region edge, including the wrap
    for (int p = 0; p < 9; p++) begin
      do_write(pool[p], 7, 1'b0, "R5");
      do_read(1'b1, pool[p], 9, 1'b0, "R5");
    end

    // R7 R6: constrained random mix of frames
    for (int it = 0; it < 24; it++) begin
      logic [15:0] a;
      int n, op;
      a  = (($urandom % 2) == 0) ? pool[$urandom % 9] + 16'($urandom % 3) : 16'($urandom);
      n  = 1 + ($urandom % 11);
      op = $urandom % 3;
      if (op == 0)      do_write(a, n, 1'b0, "R6");
      else if (op == 1) do_read(1'b1, a, n, 1'b0, "R7");
      else              do_read(1'b0, a, n, 1'b0, "R7");
    end

    check(r11_bad == 0, "R11", 16'(r11_bad), 16'd0);
    finished = 1'b1;
    summary();
  end
endmodule